// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. Software uses four word-aligned registers to select one of eight analog inputs and to arm the converter. The converter is powered through an output pin. After a programmable settling interval, measured in converter clock periods, the block resolves the sampled input one bit per converter clock. It drives a trial code to an external DAC and reads back a comparator decision. The multiplexer, DAC and comparator are outside the block and appear only as ports.

A conversion starts when software writes the control register with the power bit set. The block does not need a separate start bit. When the last bit is resolved, the block stores the code right-aligned in the result register, clears busy and raises a completion flag. It drives the interrupt line whenever software has enabled it. The converter stays powered until software writes the control register with the power bit clear. The converter clock is derived from the bus clock by a parameterised divider.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is asserted, the interrupt, power and DAC outputs are 0, the result, status and control registers read 0, and the delay register reads 8.
- R2: Register offsets are 0x0 result, 0x4 status, 0x8 control and 0xC delay. Any other offset reads 0, and every bit not defined below reads 0.
- R3: In the control register, bit 6 is the completion flag (read-only), bit 5 is interrupt enable, bit 3 is power and bits 2:0 are the channel. A control write made while not busy loads enable, power and channel and clears the completion flag. If bit 3 is set, the same write also starts one conversion of the written channel.
- R4: Status bit 0 (busy) is 1 from the edge that accepts a starting write until the edge that completes the conversion. With a delay value D, the first trial code is presented after D+1 converter ticks have elapsed.
- R5: A converter tick occurs once every CLK_DIV bus clocks. A conversion therefore keeps busy high for between (D+RES)*CLK_DIV+1 and (D+RES+1)*CLK_DIV bus clocks.
- R6: Resolution runs from MSB to LSB. While resolving, the DAC port carries the bits already kept plus the current trial bit. The trial bit is kept when the comparator input is 1 at the tick. Outside resolution the DAC port is 0.
- R7: On the last tick the code is stored right-aligned in the result register with the upper bits reading 0. Busy clears and the completion flag sets on that same edge.
- R8: The interrupt output is 1 exactly when both the completion flag and interrupt enable are 1.
- R9: A control write made while busy is ignored entirely. Channel, enable, power and the flag keep their values.
- R10: The power output follows the power bit. It stays 1 after completion until a control write with bit 3 clear, and writing 0 clears power, enable and the flag.
- R11: The delay register keeps only the 6 low bits of a write. Writes are accepted at any time and take effect at the next start.
- R12: Reset is asynchronous. Its release takes effect two bus clock edges after the reset input rises, and writes before that point are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| afe_pwr_en | output | 1 | Converter power enable |
| afe_chan | output | 3 | Analog multiplexer select |
| afe_dac_code | output | RES | Trial code to the DAC |
| afe_cmp_hi | input | 1 | Comparator: input is at or above the DAC level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with RES=12 and CLK_DIV=3. The 12-bit setting exercises the wide result, including full-scale codes of 0 and 4095. The divider value of 3 lets the starting write land at every phase of the converter tick, so the busy length moves inside its allowed window. Delay values of 0, 8 and 63 reach both ends of the settle counter.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CH_W   = 3;
  localparam int DLY_W  = 6;

  localparam logic [ADDR_W-1:0] OFS_RESULT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CONTROL = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_DELAY   = 4'hC;

  localparam int BIT_FLAG = 6;
  localparam int BIT_IEN  = 5;
  localparam int BIT_PWR  = 3;

  localparam logic [DLY_W-1:0] DLY_RESET = 6'd8;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_SETTLE  = 2'd1,
    SEQ_RESOLVE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_seq_tick.sv
`timescale 1ns/1ps
module sar_seq_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sar_seq_approx.sv
`timescale 1ns/1ps
module sar_seq_approx
  import sar_seq_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  input  logic             cmp_hi,
  output logic             busy,
  output logic             resolving,
  output logic             done,
  output logic [RES-1:0]   dac_code,
  output logic [RES-1:0]   result
);
  localparam int IDX_W = $clog2(RES);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES - 1);

  seq_state_t       st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [RES-1:0]   acc_q, acc_d;
  logic [RES-1:0]   res_q, res_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    idx_d  = idx_q;
    res_d  = res_q;
    done_d = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d  = SEQ_SETTLE;
          cnt_d = dly;
        end
      end
      SEQ_SETTLE: begin
        if (tick) begin
          if (cnt_q == '0) begin
            st_d  = SEQ_RESOLVE;
            acc_d = '0;
            idx_d = IDX_TOP;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      SEQ_RESOLVE: begin
        if (tick) begin
          acc_d[idx_q] = cmp_hi;
          if (idx_q == '0) begin
            st_d   = SEQ_IDLE;
            res_d  = acc_d;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      acc_q <= '0;
      idx_q <= '0;
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      idx_q <= idx_d;
      res_q <= res_d;
    end
  end

  assign busy      = (st_q != SEQ_IDLE);
  assign resolving = (st_q == SEQ_RESOLVE);
  assign done      = done_d;
  assign dac_code  = resolving ? (acc_q | (RES'(1) << idx_q)) : '0;
  assign result    = res_q;
endmodule

// File: rtl/sar_seq_regs.sv
`timescale 1ns/1ps
module sar_seq_regs
  import sar_seq_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [RES-1:0]    result,
  output logic [DATA_W-1:0] rdata,
  output logic              start,
  output logic              flag,
  output logic              ien,
  output logic              pwr,
  output logic [CH_W-1:0]   chan,
  output logic [DLY_W-1:0]  dly
);
  logic             flag_q, flag_d;
  logic             ien_q, ien_d;
  logic             pwr_q, pwr_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             ctl_wr, dly_wr;
  logic             unused_wbits;

  assign ctl_wr = wr && (addr == OFS_CONTROL) && !busy;
  assign dly_wr = wr && (addr == OFS_DELAY);
  assign start  = ctl_wr && wdata[BIT_PWR];
  assign unused_wbits = ^{wdata[DATA_W-1:7], wdata[4]};

  always_comb begin
    flag_d = flag_q;
    ien_d  = ien_q;
    pwr_d  = pwr_q;
    chan_d = chan_q;
    dly_d  = dly_q;
    if (ctl_wr) begin
      ien_d  = wdata[BIT_IEN];
      pwr_d  = wdata[BIT_PWR];
      chan_d = wdata[CH_W-1:0];
      flag_d = 1'b0;
    end
    if (done) flag_d = 1'b1;
    if (dly_wr) dly_d = wdata[DLY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      pwr_q  <= 1'b0;
      chan_q <= '0;
      dly_q  <= DLY_RESET;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
      pwr_q  <= pwr_d;
      chan_q <= chan_d;
      dly_q  <= dly_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_RESULT:  rdata = DATA_W'(result);
      OFS_STATUS:  rdata = DATA_W'(busy);
      OFS_CONTROL: begin
        rdata[BIT_FLAG]   = flag_q;
        rdata[BIT_IEN]    = ien_q;
        rdata[BIT_PWR]    = pwr_q;
        rdata[CH_W-1:0]   = chan_q;
      end
      OFS_DELAY:   rdata = DATA_W'(dly_q);
      default:     rdata = '0;
    endcase
  end

  assign flag = flag_q;
  assign ien  = ien_q;
  assign pwr  = pwr_q;
  assign chan = chan_q;
  assign dly  = dly_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES     = 10,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              afe_pwr_en,
  output logic [CH_W-1:0]   afe_chan,
  output logic [RES-1:0]    afe_dac_code,
  input  logic              afe_cmp_hi,
  output logic              irq
);
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             tick;
  logic             start, busy, resolving, done;
  logic             flag, ien, pwr;
  logic [CH_W-1:0]  chan;
  logic [DLY_W-1:0] dly;
  logic [RES-1:0]   result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sar_seq_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  sar_seq_regs #(.RES(RES)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .busy   (busy),
    .done   (done),
    .result (result),
    .rdata  (bus_rdata),
    .start  (start),
    .flag   (flag),
    .ien    (ien),
    .pwr    (pwr),
    .chan   (chan),
    .dly    (dly)
  );

  sar_seq_approx #(.RES(RES)) u_approx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .start     (start),
    .dly       (dly),
    .cmp_hi    (afe_cmp_hi),
    .busy      (busy),
    .resolving (resolving),
    .done      (done),
    .dac_code  (afe_dac_code),
    .result    (result)
  );

  assign afe_pwr_en = pwr;
  assign afe_chan   = chan;
  assign irq        = flag & ien;
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int RES     = 10,
  parameter int CLK_DIV = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           busy,
  input logic           resolving,
  input logic           flag,
  input logic           ien,
  input logic           pwr,
  input logic [2:0]     chan,
  input logic [RES-1:0] dac_code,
  input logic           irq
);
  a_r7_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flag);

  a_r9_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(chan) && $stable(ien) && $stable(pwr)));

  a_r10_busy_powered: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pwr);

  a_r6_code_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !resolving |-> (dac_code == '0));

  a_r6_trial_present: assert property (@(posedge clk) disable iff (!rst_n)
    resolving |-> (dac_code != '0));

  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ((CLK_DIV > 1) && tick) |=> !tick);

  a_r8_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
endmodule

bind sar_seq_ctrl sar_seq_chk #(.RES(RES), .CLK_DIV(CLK_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick      (tick),
  .busy      (busy),
  .resolving (resolving),
  .flag      (flag),
  .ien       (ien),
  .pwr       (pwr),
  .chan      (chan),
  .dac_code  (afe_dac_code),
  .irq       (irq)
);

// File: tb/sim_sar_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sar_seq_ctrl;
  localparam int RES = 12;
  localparam int DIV = 3;
  localparam int FULL = (1 << RES) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'hC;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        afe_pwr_en;
  logic [2:0]  afe_chan;
  logic [RES-1:0] afe_dac_code;
  logic        afe_cmp_hi;
  logic        irq;

  int vin [8];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign afe_cmp_hi = (vin[afe_chan] >= int'(afe_dac_code));

  sar_seq_ctrl #(.RES(RES), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .afe_pwr_en(afe_pwr_en),
    .afe_chan(afe_chan), .afe_dac_code(afe_dac_code), .afe_cmp_hi(afe_cmp_hi),
    .irq(irq)
  );

  // behavioural reference model
  int m_sync, m_dv, m_st, m_cnt, m_acc, m_idx, m_res;
  int m_ien, m_flag, m_pwr, m_chan, m_dly;

  task automatic model_reset();
    m_sync = 0; m_dv = 0; m_st = 0; m_cnt = 0; m_acc = 0; m_idx = 0;
    m_res = 0; m_ien = 0; m_flag = 0; m_pwr = 0; m_chan = 0; m_dly = 8;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit tk, busy0, fin;
      tk = (m_dv == DIV - 1);
      m_dv = tk ? 0 : m_dv + 1;
      busy0 = (m_st != 0);
      fin = 0;
      if (m_st == 1 && tk) begin
        if (m_cnt == 0) begin m_st = 2; m_acc = 0; m_idx = RES - 1; end
        else m_cnt--;
      end else if (m_st == 2 && tk) begin
        int code;
        code = m_acc | (1 << m_idx);
        if (vin[m_chan] >= code) m_acc = code;
        if (m_idx == 0) begin m_st = 0; m_res = m_acc; fin = 1; end
        else m_idx--;
      end
      if (bus_wr && bus_addr == 4'h8 && !busy0) begin
        m_ien = bus_wdata[5]; m_pwr = bus_wdata[3]; m_chan = bus_wdata[2:0];
        m_flag = 0;
        if (bus_wdata[3]) begin m_st = 1; m_cnt = m_dly; end
      end
      if (fin) m_flag = 1;
      if (bus_wr && bus_addr == 4'hC) m_dly = bus_wdata[5:0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata(logic [3:0] a);
    case (a)
      4'h0: return m_res;
      4'h4: return (m_st != 0) ? 1 : 0;
      4'h8: return (m_flag << 6) | (m_ien << 5) | (m_pwr << 3) | m_chan;
      4'hC: return m_dly;
      default: return 0;
    endcase
  endfunction

  // per-clock comparison, away from the edges
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      string t;
      case (bus_addr)
        4'h0: t = "R7 result read";
        4'h4: t = "R4 busy read";
        4'h8: t = "R3 control read";
        4'hC: t = "R11 delay read";
        default: t = "R2 unmapped read";
      endcase
      chk(t, int'(bus_rdata), exp_rdata(bus_addr));
      chk("R8 irq", int'(irq), m_flag & m_ien);
      chk("R10 power", int'(afe_pwr_en), m_pwr);
      chk("R9 channel", int'(afe_chan), m_chan);
      chk("R6 dac code", int'(afe_dac_code),
          (m_st == 2) ? (m_acc | (1 << m_idx)) : 0);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h4; bus_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #4 v = int'(bus_rdata);
  endtask

  // returns number of busy bus cycles after a starting write
  task automatic wait_idle(output int n);
    n = 0;
    bus_addr = 4'h4;
    forever begin
      #3;
      if (!bus_rdata[0]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic convert(int ch, int ien, int d, string tag);
    int n, v, lo, hi;
    wr(4'hC, d);
    wr(4'h8, (ien << 5) | 8 | ch);
    wait_idle(n);
    lo = (d + RES) * DIV + 1;
    hi = (d + RES + 1) * DIV;
    checks++;
    if (n < lo || n > hi) begin
      errors++;
      $display("FAIL R5 %s busy cycles actual=%0d expected=%0d..%0d", tag, n, lo, hi);
    end
    rd(4'h0, v);
    chk({"R7 ", tag}, v, (vin[ch] > FULL) ? FULL : vin[ch]);
    rd(4'h8, v);
    chk({"R3 ", tag, " flag"}, (v >> 6) & 1, 1);
    chk({"R8 ", tag}, int'(irq), ien);
  endtask

  initial begin
    int v;
    for (int i = 0; i < 8; i++) vin[i] = 0;
    // R1: reset state
    #35;
    chk("R1 irq", int'(irq), 0);
    chk("R1 power", int'(afe_pwr_en), 0);
    chk("R1 dac", int'(afe_dac_code), 0);
    chk("R1 delay", int'(bus_rdata), 8);
    bus_addr = 4'h8;
    #1 chk("R1 control", int'(bus_rdata), 0);
    // R12: write during reset release window is ignored
    @(negedge clk);
    rst_n = 1'b1;
    bus_wr = 1'b1; bus_wdata = 32'h2B;
    @(negedge clk);
    bus_wr = 1'b0;
    #4 chk("R12 early write", int'(bus_rdata), 0);
    repeat (4) @(negedge clk);
    // R2: unmapped offset
    bus_addr = 4'h6;
    repeat (2) @(negedge clk);

    vin[0] = 0; vin[1] = 1234; vin[2] = 2731; vin[3] = FULL;
    vin[4] = 2048; vin[5] = 2047; vin[6] = 5000; vin[7] = 1;

    convert(2, 1, 8, "ch2 d8");
    chk("R10 power held", int'(afe_pwr_en), 1);
    convert(1, 0, 0, "ch1 d0 no ien");
    convert(0, 1, 0, "ch0 zero");
    convert(3, 1, 1, "ch3 full");
    convert(6, 1, 2, "ch6 overrange");
    for (int k = 0; k < 6; k++) convert(4 + (k % 2), k % 2, k, "phase sweep");
    convert(7, 1, 5, "ch7 one");

    // R9: writes while busy are ignored
    wr(4'hC, 3);
    wr(4'h8, 32'h2D);
    repeat (3) @(negedge clk);
    wr(4'h8, 32'h00);
    wr(4'h8, 32'h21);
    rd(4'h8, v);
    chk("R9 ignored write channel", v & 7, 5);
    chk("R9 ignored write power", int'(afe_pwr_en), 1);
    begin int n; wait_idle(n); end
    rd(4'h0, v);
    chk("R9 result of channel 5", v, vin[5]);

    // R10: writing zero powers down and clears flag and enable
    wr(4'h8, 32'h00);
    rd(4'h8, v);
    chk("R10 control cleared", v, 0);
    chk("R10 power off", int'(afe_pwr_en), 0);
    chk("R8 irq off", int'(irq), 0);
    wr(4'h8, 32'h24);
    rd(4'h4, v);
    chk("R3 no start without power", v, 0);

    // R11: only six bits of delay kept
    wr(4'hC, 32'hFFFF_FFC7);
    rd(4'hC, v);
    chk("R11 delay mask", v, 7);
    convert(1, 1, 63, "ch1 d63");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule